// File: doc/BRIEF.md
# Configurable UART Transmitter

This block turns one parallel data word into an asynchronous serial frame on a single output line. The frame format is read from input pins at the moment a transfer begins. The format covers the number of data bits (from 5 up to the full word width), whether a parity bit is sent and which sense it has, and whether one or two stop bits close the frame. The bit period is set by a clock divider input, so no fixed baud rate is built in.

A transfer is requested with a pulse on the write-enable input: the pin is raised and then lowered. The frame starts on the falling edge if no frame is in progress. A busy output stays high for the whole frame. The surrounding logic uses it to know when the next word can be requested. Filling the transmitter from a queue or from host-visible registers is left to other blocks.

Top module: `uart_tx_core`

## Requirements
- R1: While rst_n is low (asynchronous, active low), tx is 1 and busy is 0.
- R2: With no frame in progress, tx stays at 1 and busy stays at 0. Raising wr_en alone starts nothing.
- R3: A frame starts when wr_en is sampled 0 on a rising clock edge after being sampled 1 on the previous edge while busy is 0. From that edge on, tx carries the start bit 0 and busy is 1.
- R4: Every bit of the frame lasts exactly clk_div+1 clock cycles.
- R5: After the start bit, word_len+1 data bits are sent LSB first. tx_data bit 0 goes out first.
- R6: A word_len value above DATA_W-1 sends DATA_W data bits. With the defaults, values 16 to 31 send 16 bits.
- R7: With par_en 0, no parity bit is sent. With par_en 1, one parity bit follows the data. With par_odd 0, this bit makes the count of ones over the data and parity bits even. With par_odd 1, the count is odd.
- R8: The frame ends with one stop bit at 1, or two when two_stop is 1. busy falls at the end of the last stop bit, and tx then stays at 1.
- R9: A wr_en falling edge seen while busy is 1 is ignored. No second frame follows the current one.
- R10: tx_data, word_len, par_en, par_odd and two_stop are captured when the frame starts. Changing them during the frame does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_data | input | DATA_W | Word to send |
| word_len | input | LEN_W | Number of data bits minus one |
| par_en | input | 1 | Send a parity bit when 1 |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| two_stop | input | 1 | 0 gives one stop bit, 1 gives two |
| clk_div | input | DIV_W | Bit period minus one, in clock cycles |
| wr_en | input | 1 | Transfer request, acts on its falling edge |
| tx | output | 1 | Serial line, idles high |
| busy | output | 1 | High while a frame is being sent |

## Verification
The bench uses the default parameters: DATA_W of 16, LEN_W of 5 and DIV_W of 16. With these values a full 16-bit word can be sent. The 5-bit length field can also encode values from 16 to 31, which reaches the clamp of R6. Divider values from 0 to 3 keep each frame short. They still allow checks on the first and the last cycle of every bit. The one-cycle divider setting covers the case where each bit lasts a single clock. The five-bit frame with two stop bits is also used to show that a request and new inputs arriving during a frame are ignored.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP1  = 3'd4,
        ST_STOP2  = 3'd5
    } tx_state_e;

    typedef struct packed {
        logic par_en;
        logic par_odd;
        logic two_stop;
    } frame_fmt_t;

    localparam int MAX_W = 32;

    // xor of the word bits selected by mask, inverted for odd sense
    function automatic logic frame_parity(input logic [MAX_W-1:0] word,
                                          input logic [MAX_W-1:0] mask,
                                          input logic             odd);
        return (^(word & mask)) ^ odd;
    endfunction

endpackage

// File: rtl/uart_tx_edge.sv
module uart_tx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic req_in,
    output logic req_fall
);
    logic req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_in;
    end

    assign req_fall = req_q & ~req_in;
endmodule

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (restart || !run)  cnt <= '0;
        else if (cnt == div)       cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    input  logic [DATA_W-1:0] data,
    input  logic [LEN_W-1:0]  len,
    input  frame_fmt_t        fmt,
    output logic              tx,
    output logic              busy
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DATA_W - 1);

    tx_state_e         state;
    logic [DATA_W-1:0] shreg;
    logic [IDX_W-1:0]  idx_cur;
    logic [IDX_W-1:0]  idx_last;
    logic              par_bit;
    frame_fmt_t        fmt_q;

    logic [IDX_W-1:0]  last_clamped;
    logic [MAX_W-1:0]  sel_mask;
    logic [MAX_W-1:0]  word_ext;
    logic              par_calc;

    always_comb begin
        if (len > LEN_MAX) last_clamped = IDX_W'(DATA_W - 1);
        else               last_clamped = IDX_W'(len);
    end

    for (genvar gi = 0; gi < MAX_W; gi++) begin : g_mask
        if (gi < DATA_W) begin : g_used
            assign sel_mask[gi] = (gi <= int'(last_clamped));
            assign word_ext[gi] = data[gi];
        end else begin : g_pad
            assign sel_mask[gi] = 1'b0;
            assign word_ext[gi] = 1'b0;
        end
    end

    assign par_calc = frame_parity(word_ext, sel_mask, fmt.par_odd);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            idx_cur  <= '0;
            idx_last <= '0;
            par_bit  <= 1'b0;
            fmt_q    <= '0;
        end else if (start) begin
            state    <= ST_START;
            shreg    <= data;
            idx_cur  <= '0;
            idx_last <= last_clamped;
            par_bit  <= par_calc;
            fmt_q    <= fmt;
        end else if (tick) begin
            unique case (state)
                ST_START: state <= ST_DATA;
                ST_DATA: begin
                    if (idx_cur == idx_last) begin
                        state <= fmt_q.par_en ? ST_PARITY : ST_STOP1;
                    end else begin
                        idx_cur <= idx_cur + 1'b1;
                        shreg   <= shreg >> 1;
                    end
                end
                ST_PARITY: state <= ST_STOP1;
                ST_STOP1:  state <= fmt_q.two_stop ? ST_STOP2 : ST_IDLE;
                ST_STOP2:  state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_START:  tx = 1'b0;
            ST_DATA:   tx = shreg[0];
            ST_PARITY: tx = par_bit;
            default:   tx = 1'b1;
        endcase
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 5,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [LEN_W-1:0]  word_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              wr_en,
    output logic              tx,
    output logic              busy
);
    logic       req_fall;
    logic       start;
    logic       tick;
    frame_fmt_t fmt;

    assign fmt   = '{par_en: par_en, par_odd: par_odd, two_stop: two_stop};
    assign start = req_fall & ~busy;

    uart_tx_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_in   (wr_en),
        .req_fall (req_fall)
    );

    uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .restart (start),
        .div     (clk_div),
        .tick    (tick)
    );

    uart_tx_frame #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_frame (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .tick  (tick),
        .data  (tx_data),
        .len   (word_len),
        .fmt   (fmt),
        .tx    (tx),
        .busy  (busy)
    );
endmodule

// File: rtl/uart_tx_core_chk.sv
module uart_tx_core_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic tx,
    input logic busy
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_idle: assert (tx && !busy)
                else $error("R1: line not idle in reset");
        end
    end

    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx);

    a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx);

    a_r3_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(wr_en, 2) && !$past(wr_en)));

    a_r8_stop_before_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(tx) && tx));
endmodule

bind uart_tx_core uart_tx_core_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .tx    (tx),
    .busy  (busy)
);

// File: tb/uart_tx_core_test.sv
`timescale 1ns/1ps
module uart_tx_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tx_data = '0;
    logic [4:0]  word_len = '0;
    logic        par_en = 1'b0;
    logic        par_odd = 1'b0;
    logic        two_stop = 1'b0;
    logic [15:0] clk_div = '0;
    logic        wr_en = 1'b0;
    logic        tx;
    logic        busy;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_tx_core uut (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .word_len(word_len),
        .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
        .clk_div(clk_div), .wr_en(wr_en), .tx(tx), .busy(busy)
    );

    task automatic check(input logic act, input logic exp, input string req, input string what);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic test_reset();
        check(tx, 1'b1, "R1", "tx in reset");
        check(busy, 1'b0, "R1", "busy in reset");
    endtask

    task automatic test_idle();
        @(negedge clk);
        check(tx, 1'b1, "R2", "tx idle");
        check(busy, 1'b0, "R2", "busy idle");
        wr_en = 1'b1;
        repeat (4) @(negedge clk);
        check(tx, 1'b1, "R2", "tx with wr_en held high");
        check(busy, 1'b0, "R2", "busy with wr_en held high");
        wr_en = 1'b0;
        // that release starts a frame of the current setup: 1 data bit clamp? len=0 -> 1 bit
        repeat (3 * 1 + 4) @(negedge clk);
        check(busy, 1'b0, "R2", "idle again after short frame");
    endtask

    // send one frame and check every bit; optionally disturb inputs at bit 2
    task automatic send_frame(input logic [15:0] d, input logic [4:0] len,
                              input logic pe, input logic po, input logic ts,
                              input int div, input bit disturb, input string dreq);
        logic exp_bits [0:20];
        string reqs [0:20];
        int nb, total, ones;
        @(negedge clk);
        tx_data = d; word_len = len; par_en = pe; par_odd = po; two_stop = ts;
        clk_div = 16'(div);
        nb = (len > 15) ? 16 : int'(len) + 1;
        total = 0; ones = 0;
        exp_bits[total] = 1'b0; reqs[total] = "R3"; total++;
        for (int i = 0; i < nb; i++) begin
            exp_bits[total] = d[i]; reqs[total] = dreq; total++;
            if (d[i]) ones++;
        end
        if (pe) begin
            exp_bits[total] = logic'(ones % 2) ^ po; reqs[total] = "R7"; total++;
        end
        exp_bits[total] = 1'b1; reqs[total] = "R8"; total++;
        if (ts) begin exp_bits[total] = 1'b1; reqs[total] = "R8"; total++; end
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        for (int b = 0; b < total; b++) begin
            check(tx, exp_bits[b], reqs[b], $sformatf("bit %0d first cycle", b));
            check(busy, 1'b1, "R3", $sformatf("busy during bit %0d", b));
            if (disturb && b == 2) begin
                wr_en = 1'b1;
                tx_data = ~d; word_len = 5'd15; par_en = ~pe; two_stop = ~ts;
            end
            for (int k = 0; k <= div; k++) begin
                @(negedge clk);
                if (k == 0) wr_en = 1'b0;
                if (div > 0 && k == div - 1)
                    check(tx, exp_bits[b], "R4", $sformatf("bit %0d last cycle", b));
            end
        end
        check(busy, 1'b0, "R8", "busy after last stop");
        check(tx, 1'b1, "R8", "tx after last stop");
        repeat (2 * (div + 1) + 2) @(negedge clk);
        check(busy, 1'b0, disturb ? "R9" : "R8", "no further frame");
        check(tx, 1'b1, disturb ? "R9" : "R8", "line stays idle");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_idle();
        send_frame(16'h00A5, 5'd7, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R5");
        send_frame(16'h003C, 5'd7, 1'b1, 1'b0, 1'b0, 3, 1'b0, "R5");
        send_frame(16'h0055, 5'd6, 1'b1, 1'b1, 1'b1, 1, 1'b0, "R5");
        send_frame(16'hB3C1, 5'd15, 1'b1, 1'b1, 1'b0, 2, 1'b0, "R5");
        send_frame(16'hF00E, 5'd31, 1'b1, 1'b0, 1'b0, 1, 1'b0, "R6");
        send_frame(16'h0016, 5'd4, 1'b0, 1'b0, 1'b1, 3, 1'b1, "R10");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule